// File: doc/BRIEF.md
# Configurable Input Macrocell Bank

This block conditions the pins of three 8-bit I/O ports before they reach a programmable logic input bus. Each pin has its own macrocell, and each macrocell passes the pin on in one of three ways: unchanged, through a level-sensitive hold stage, or through an edge-captured stage. The enable for the hold or capture stage comes from one of two sources: a product-term strobe from the logic array or the address latch enable (ALE) strobe. That choice is made once for each group of four neighbouring cells, and all four cells of a group share it. All configuration comes from static inputs.

A processor can read the current output of every cell of a port through one byte-wide register per port, decoded at a fixed offset from a base address. Bits that belong to pins reserved for boundary-scan use on the third port read back as zero. A parameter can remove the first port entirely for reduced-pin builds. All strobes are treated as signals synchronous to the block clock and are sampled by it.

Top module: `imc_bank`

## Requirements
- R1: A cell whose 2-bit mode code is 00 (direct) or 11 (reserved) drives its bus bit combinationally from its pin.
- R2: A cell in mode 01 (latched) drives its pin combinationally while its selected gate is high, and while the gate is low it drives the pin value seen at the last clock edge at which the gate was high.
- R3: A cell in mode 10 (registered) loads its pin at the first clock edge at which its selected strobe is seen high after being seen low, and holds that value through all other edges.
- R4: Each group of four cells has one source select bit at index port*2+group (group 0 holds cells 0-3, group 1 holds cells 4-7): 1 picks ALE, 0 picks the product-term strobe at the same index; a strobe on the unselected source has no effect.
- R5: While the synchronous active-high reset is high at a clock edge, all held and captured state is cleared to 0, overriding any capture.
- R6: With the read enable high at a clock edge and the address equal to base+0x0A, base+0x0B or base+0x18, the read data after that edge is the outputs of port A, B or C respectively, bit n coming from cell n.
- R7: With the read enable low, or with an address matching none of the three offsets, the read data after the edge is 0x00.
- R8: A read of port C returns 0 in bits 0, 1, 5 and 6, while those cells still drive the bus normally.
- R9: With the port A parameter cleared, port A bus bits are constant 0 and a read at base+0x0A returns 0x00; ports B and C behave as usual.
- R10: A read at the same edge as a capture returns the cell values from before that edge's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch enable strobe |
| ptGate | input | 6 | Product-term strobe per group, index port*2+group |
| clkSrcSel | input | 6 | Per-group source select, 1 = ALE, 0 = product term |
| cellMode | input | 48 | 2-bit mode per cell, bits (port*8+cell)*2 +: 2 |
| pinIn | input | 24 | Pin inputs, bit port*8+cell |
| busOut | output | 24 | Cell outputs to the logic input bus, bit port*8+cell |
| rdEn | input | 1 | Processor read strobe |
| rdAddr | input | ADDR_W | Processor read address |
| rdData | output | 8 | Read data, valid one cycle after the strobe |

## Verification
The two functions that can meet in one cycle are a processor read and an update of the cell it reads: an edge that captures a new value in registered mode, or a gate held open in latched mode. The bench provokes both by raising the read strobe at the very edge where ALE rises on registered port C cells, and by reading port A while its product-term gate is open with a fresh pin value. The read is judged against the pre-capture register value and against the live pin value respectively, and the following read must show the captured value.

// File: rtl/imc_pkg.sv
package imc_pkg;

  localparam int NUM_PORTS       = 3;
  localparam int CELLS_PER_PORT  = 8;
  localparam int CELLS_PER_GROUP = 4;
  localparam int MODE_W          = 2;
  localparam int GROUPS_PER_PORT = CELLS_PER_PORT / CELLS_PER_GROUP;
  localparam int NUM_GROUPS      = NUM_PORTS * GROUPS_PER_PORT;
  localparam int NUM_CELLS       = NUM_PORTS * CELLS_PER_PORT;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT = 2'b00,
    MODE_LATCH  = 2'b01,
    MODE_REG    = 2'b10,
    MODE_RSVD   = 2'b11
  } cellMode_e;

  // strobes handed from the control to the datapath
  typedef struct packed {
    logic [NUM_GROUPS-1:0] gate;
    logic [NUM_GROUPS-1:0] rise;
    logic [NUM_PORTS-1:0]  readSel;
  } ctrlStrobes_t;

  // readback offset of each port from the base address
  function automatic int portOffset(input int port);
    case (port)
      0:       return 'h0A;
      1:       return 'h0B;
      default: return 'h18;
    endcase
  endfunction

  // bits forced to zero on readback (boundary-scan pins on port C)
  function automatic logic [CELLS_PER_PORT-1:0] portUndefMask(input int port);
    if (port == 2) return 8'b0110_0011;
    return '0;
  endfunction

endpackage

// File: rtl/imc_ctrl.sv
module imc_ctrl
  import imc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h40
) (
  input  logic                  clk,
  input  logic                  ale,
  input  logic [NUM_GROUPS-1:0] ptGate,
  input  logic [NUM_GROUPS-1:0] clkSrcSel,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output ctrlStrobes_t          strobes
);

  logic [NUM_GROUPS-1:0] gateNow;
  logic [NUM_GROUPS-1:0] gatePrev;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_src
    assign gateNow[g] = clkSrcSel[g] ? ale : ptGate[g];
  end

  // previous sample follows the gate even in reset, so a rise is only
  // ever reported for a genuine low-to-high step seen by the clock
  always_ff @(posedge clk) begin
    gatePrev <= gateNow;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    localparam logic [ADDR_W-1:0] HitAddr = ADDR_W'(BASE_ADDR + portOffset(p));
    assign strobes.readSel[p] = rdEn && (rdAddr == HitAddr);
  end

  assign strobes.gate = gateNow;
  assign strobes.rise = gateNow & ~gatePrev;

endmodule

// File: rtl/imc_cell.sv
module imc_cell
  import imc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pin,
  input  logic              gate,
  input  logic              rise,
  input  logic [MODE_W-1:0] mode,
  output logic              cellOut
);

  logic latchQ;
  logic regQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ <= 1'b0;
      regQ   <= 1'b0;
    end else begin
      if (gate) latchQ <= pin;
      if (rise) regQ   <= pin;
    end
  end

  always_comb begin
    case (cellMode_e'(mode))
      MODE_LATCH: cellOut = gate ? pin : latchQ;
      MODE_REG:   cellOut = regQ;
      default:    cellOut = pin;
    endcase
  end

endmodule

// File: rtl/imc_datapath.sv
module imc_datapath
  import imc_pkg::*;
#(
  parameter bit PORT_A_PRESENT = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CELLS-1:0]        pinIn,
  input  logic [NUM_CELLS*MODE_W-1:0] cellMode,
  input  ctrlStrobes_t                strobes,
  output logic [NUM_CELLS-1:0]        busOut,
  output logic [CELLS_PER_PORT-1:0]   rdData
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p == 0 && !PORT_A_PRESENT) begin : g_absent
      logic unusedPortA;
      assign unusedPortA = ^{pinIn[CELLS_PER_PORT-1:0],
                             cellMode[CELLS_PER_PORT*MODE_W-1:0]};
      assign busOut[CELLS_PER_PORT-1:0] = '0;
    end else begin : g_present
      for (genvar c = 0; c < CELLS_PER_PORT; c++) begin : g_cell
        localparam int Idx = p * CELLS_PER_PORT + c;
        localparam int Grp = p * GROUPS_PER_PORT + c / CELLS_PER_GROUP;
        imc_cell u_cell (
          .clk    (clk),
          .rst    (rst),
          .pin    (pinIn[Idx]),
          .gate   (strobes.gate[Grp]),
          .rise   (strobes.rise[Grp]),
          .mode   (cellMode[Idx*MODE_W +: MODE_W]),
          .cellOut(busOut[Idx])
        );
      end
    end
  end

  logic [CELLS_PER_PORT-1:0] readNext;

  always_comb begin
    readNext = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strobes.readSel[p])
        readNext |= busOut[p*CELLS_PER_PORT +: CELLS_PER_PORT] & ~portUndefMask(p);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= readNext;
  end

endmodule

// File: rtl/imc_bank.sv
module imc_bank
  import imc_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int BASE_ADDR      = 'h40,
  parameter bit PORT_A_PRESENT = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ale,
  input  logic [NUM_GROUPS-1:0]       ptGate,
  input  logic [NUM_GROUPS-1:0]       clkSrcSel,
  input  logic [NUM_CELLS*MODE_W-1:0] cellMode,
  input  logic [NUM_CELLS-1:0]        pinIn,
  output logic [NUM_CELLS-1:0]        busOut,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [CELLS_PER_PORT-1:0]   rdData
);

  ctrlStrobes_t strobes;

  imc_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .ale      (ale),
    .ptGate   (ptGate),
    .clkSrcSel(clkSrcSel),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .strobes  (strobes)
  );

  imc_datapath #(
    .PORT_A_PRESENT(PORT_A_PRESENT)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .pinIn   (pinIn),
    .cellMode(cellMode),
    .strobes (strobes),
    .busOut  (busOut),
    .rdData  (rdData)
  );

endmodule

// File: rtl/imc_bank_chk.sv
module imc_bank_chk
  import imc_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int BASE_ADDR      = 'h40,
  parameter bit PORT_A_PRESENT = 1'b1
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        ale,
  input logic [NUM_GROUPS-1:0]       ptGate,
  input logic [NUM_GROUPS-1:0]       clkSrcSel,
  input logic [NUM_CELLS*MODE_W-1:0] cellMode,
  input logic [NUM_CELLS-1:0]        pinIn,
  input logic [NUM_CELLS-1:0]        busOut,
  input logic                        rdEn,
  input logic [ADDR_W-1:0]           rdAddr,
  input logic [CELLS_PER_PORT-1:0]   rdData
);

  localparam logic [ADDR_W-1:0] AddrB = ADDR_W'(BASE_ADDR + portOffset(1));
  localparam logic [ADDR_W-1:0] AddrC = ADDR_W'(BASE_ADDR + portOffset(2));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    if (p != 0 || PORT_A_PRESENT) begin : g_on
      for (genvar c = 0; c < CELLS_PER_PORT; c++) begin : g_c
        localparam int Idx = p * CELLS_PER_PORT + c;
        localparam int Grp = p * GROUPS_PER_PORT + c / CELLS_PER_GROUP;
        logic [MODE_W-1:0] m;
        logic g, isLatch, isReg, isDirect;
        assign m        = cellMode[Idx*MODE_W +: MODE_W];
        assign g        = clkSrcSel[Grp] ? ale : ptGate[Grp];
        assign isLatch  = (m == 2'b01);
        assign isReg    = (m == 2'b10);
        assign isDirect = (m == 2'b00) || (m == 2'b11);

        a_r1_direct_pass: assert property (@(posedge clk) disable iff (rst)
          isDirect |-> busOut[Idx] == pinIn[Idx]);
        a_r2_latch_open: assert property (@(posedge clk) disable iff (rst)
          (isLatch && g) |-> busOut[Idx] == pinIn[Idx]);
        a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
          (isLatch && !g) |=> ((isLatch && !g) -> $stable(busOut[Idx])));
        a_r3_reg_capture: assert property (@(posedge clk) disable iff (rst)
          (isReg && $rose(g)) |=> (isReg -> busOut[Idx] == $past(pinIn[Idx])));
        a_r3_reg_hold: assert property (@(posedge clk) disable iff (rst)
          (isReg && !$rose(g)) |=> (isReg -> $stable(busOut[Idx])));
        a_r5_reset_clear: assert property (@(posedge clk)
          (rst && isReg) |=> (isReg -> busOut[Idx] == 1'b0));
      end
    end
  end

  if (!PORT_A_PRESENT) begin : g_noA
    a_r9_absent_zero: assert property (@(posedge clk) disable iff (rst)
      busOut[CELLS_PER_PORT-1:0] == '0);
  end

  a_r6_read_b: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == AddrB) |=> rdData == $past(busOut[2*CELLS_PER_PORT-1:CELLS_PER_PORT]));
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> rdData == '0);
  a_r8_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr == AddrC) |=> (rdData & portUndefMask(2)) == '0);

endmodule

bind imc_bank imc_bank_chk #(
  .ADDR_W        (ADDR_W),
  .BASE_ADDR     (BASE_ADDR),
  .PORT_A_PRESENT(PORT_A_PRESENT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ale      (ale),
  .ptGate   (ptGate),
  .clkSrcSel(clkSrcSel),
  .cellMode (cellMode),
  .pinIn    (pinIn),
  .busOut   (busOut),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .rdData   (rdData)
);

// File: tb/imc_bank_bench.sv
module imc_bank_bench;
  import imc_pkg::*;

  localparam int ADDR_W = 8;
  localparam int BASE   = 'h40;
  localparam logic [7:0] ADDR_A = 8'h4A;
  localparam logic [7:0] ADDR_B = 8'h4B;
  localparam logic [7:0] ADDR_C = 8'h58;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ale = 1'b0;
  logic [5:0]  ptGate = '0;
  logic [5:0]  clkSrcSel = '0;
  logic [47:0] cellMode = '0;
  logic [23:0] pinIn = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [23:0] busOut, busOutNoA;
  logic [7:0]  rdData, rdDataNoA;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  imc_bank #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .PORT_A_PRESENT(1'b1)) u_imc_bank (
    .clk(clk), .rst(rst), .ale(ale), .ptGate(ptGate), .clkSrcSel(clkSrcSel),
    .cellMode(cellMode), .pinIn(pinIn), .busOut(busOut),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData));

  imc_bank #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .PORT_A_PRESENT(1'b0)) u_imc_bank_noA (
    .clk(clk), .rst(rst), .ale(ale), .ptGate(ptGate), .clkSrcSel(clkSrcSel),
    .cellMode(cellMode), .pinIn(pinIn), .busOut(busOutNoA),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdDataNoA));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setPortMode(input int p, input logic [1:0] m);
    for (int c = 0; c < 8; c++) cellMode[(p*8+c)*2 +: 2] = m;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  task automatic t_reset();
    check("R7 rdData after reset", rdData, 8'h00);
    setPortMode(0, 2'b10); setPortMode(1, 2'b10); setPortMode(2, 2'b10);
    pinIn = 24'hFFFFFF;
    #1 check("R5 registered state cleared", busOut, 24'h000000);
    setPortMode(0, 2'b01); setPortMode(1, 2'b01); setPortMode(2, 2'b01);
    #1 check("R5 latched state cleared", busOut, 24'h000000);
    tick();
  endtask

  task automatic t_direct();
    for (int c = 0; c < 8; c++) cellMode[(8+c)*2 +: 2] = (c % 2 == 0) ? 2'b00 : 2'b11;
    pinIn[15:8] = 8'hA5;
    #1 check("R1 direct/reserved pattern A5", busOut[15:8], 8'hA5);
    pinIn[15:8] = 8'h5A;
    #1 check("R1 direct/reserved pattern 5A", busOut[15:8], 8'h5A);
    tick();
  endtask

  task automatic t_latch();
    setPortMode(0, 2'b01);
    clkSrcSel[1:0] = 2'b00;
    pinIn[7:0] = 8'h3C; ptGate[0] = 1'b1; ptGate[1] = 1'b0;
    #1 check("R2 transparent low group, held high group", busOut[7:0], 8'h0C);
    tick();
    ptGate[0] = 1'b0; pinIn[7:0] = 8'hF0;
    #1 check("R2 hold after gate closes", busOut[7:0], 8'h0C);
    ptGate[1] = 1'b1;
    #1 check("R2 R4 group 1 gate is independent", busOut[7:0], 8'hFC);
    tick();
    ptGate[1] = 1'b0; pinIn[7:0] = 8'h00;
    #1 check("R2 both groups hold", busOut[7:0], 8'hFC);
    ale = 1'b1;
    #1 check("R4 ALE ignored by product-term latch", busOut[7:0], 8'hFC);
    tick();
    check("R4 ALE edge ignored by product-term latch", busOut[7:0], 8'hFC);
    ale = 1'b0;
    tick();
  endtask

  task automatic t_register();
    setPortMode(2, 2'b10);
    clkSrcSel[4] = 1'b0; clkSrcSel[5] = 1'b1; ptGate[5:4] = 2'b00;
    pinIn[23:16] = 8'hA5;
    tick();
    check("R3 no strobe no capture", busOut[23:16], 8'h00);
    ale = 1'b1;
    tick();
    check("R3 R4 ALE rise captures group 1 only", busOut[23:16], 8'hA0);
    pinIn[23:16] = 8'h5A;
    tick();
    check("R3 strobe held high, no recapture", busOut[23:16], 8'hA0);
    ale = 1'b0;
    tick();
    check("R3 falling strobe, no capture", busOut[23:16], 8'hA0);
    ptGate[4] = 1'b1;
    tick();
    check("R3 R4 product-term rise captures group 0", busOut[23:16], 8'hAA);
    ptGate[4] = 1'b0;
    tick();
  endtask

  task automatic t_read();
    rdEn = 1'b1; rdAddr = ADDR_A;
    tick(); check("R6 read port A", rdData, 8'hFC);
    rdAddr = ADDR_B;
    tick(); check("R6 read port B", rdData, 8'h5A);
    rdAddr = ADDR_C;
    tick(); check("R8 read port C masks bits 0,1,5,6", rdData, 8'h88);
    check("R8 port C bus keeps masked bits", busOut[23:16], 8'hAA);
    rdAddr = 8'h4C;
    tick(); check("R7 non-matching address", rdData, 8'h00);
    rdEn = 1'b0; rdAddr = ADDR_A;
    tick(); check("R7 read enable low", rdData, 8'h00);
  endtask

  task automatic t_collide();
    pinIn[23:16] = 8'hFF; rdEn = 1'b1; rdAddr = ADDR_C; ale = 1'b1;
    tick();
    check("R10 read at capture edge returns old value", rdData, 8'h88);
    check("R10 capture happened at same edge", busOut[23:16], 8'hFA);
    tick();
    check("R10 next read shows captured value", rdData, 8'h98);
    ale = 1'b0;
    ptGate[0] = 1'b1; pinIn[7:0] = 8'h11; rdAddr = ADDR_A;
    tick();
    check("R10 R2 read while latch open returns pin", rdData, 8'hF1);
    rdEn = 1'b0; ptGate[0] = 1'b0;
    tick();
  endtask

  task automatic t_reset_mid();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    #1 check("R5 latched port A cleared", busOut[7:0], 8'h00);
    check("R5 registered port C cleared", busOut[23:16], 8'h00);
    check("R5 read data cleared", rdData, 8'h00);
    tick();
  endtask

  task automatic t_noA();
    setPortMode(0, 2'b00);
    pinIn[7:0] = 8'h77;
    #1 check("R9 reference port A direct", busOut[7:0], 8'h77);
    check("R9 absent port A bus zero", busOutNoA[7:0], 8'h00);
    check("R9 absent build port B unaffected", busOutNoA[15:8], busOut[15:8]);
    rdEn = 1'b1; rdAddr = ADDR_A;
    tick();
    check("R9 R6 reference read of port A", rdData, 8'h77);
    check("R9 absent port A reads zero", rdDataNoA, 8'h00);
    rdAddr = ADDR_B;
    tick();
    check("R9 absent build reads port B", rdDataNoA, 8'h5A);
    rdEn = 1'b0;
    tick();
  endtask

  initial begin
    #(20 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    t_reset();
    t_direct();
    t_latch();
    t_register();
    t_read();
    t_collide();
    t_reset_mid();
    t_noA();
    finishRun();
  end

endmodule